// File: doc/BRIEF.md
# Universal Shift and Rotate Register

This block is a W-bit register (four bits by default) whose next content is chosen each clock by a 3-bit operation select. The operations are hold, parallel load, shift toward bit 0, shift toward the MSB, rotate toward bit 0 and rotate toward the MSB. A synchronous clear overrides every operation. All bit cells share one clock and one clear and update on the same rising edge.

Each shift takes its incoming bit from a dedicated serial input, one for each end. Driving that input low gives a zero-fill shift. A rotate instead feeds the bit that leaves one end back into the other end. Two serial outputs always show the end bits, which are the bits that the next shift or rotate will push out. The block can therefore be chained, or used for serial-to-parallel and parallel-to-serial conversion.

Top module: `universal_shreg`

## Requirements
- R1: When `clr` is high at a rising edge, `dout` becomes all zeros after that edge, whatever `op_sel` holds.
- R2: With `op_sel` = 3'b000, or with either unused code 3'b110 or 3'b111, `dout` keeps its value across the edge. The data input and the serial inputs have no effect.
- R3: With `op_sel` = 3'b001, every bit of `dout` takes the value of `din` on the edge.
- R4: With `op_sel` = 3'b010 (shift toward bit 0), bit i takes the old bit i+1 and the MSB takes `ser_hi_in`.
- R5: With `op_sel` = 3'b011 (shift toward the MSB), bit i takes the old bit i-1 and bit 0 takes `ser_lo_in`.
- R6: With `op_sel` = 3'b100 (rotate toward bit 0), bit i takes the old bit i+1 and the MSB takes the old bit 0. `ser_hi_in` is ignored.
- R7: With `op_sel` = 3'b101 (rotate toward the MSB), bit i takes the old bit i-1 and bit 0 takes the old MSB. `ser_lo_in` is ignored.
- R8: `ser_lo_out` always equals `dout[0]`, and `ser_hi_out` always equals `dout[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, overrides all operations |
| op_sel | input | 3 | Operation select (encoding given in R2 to R7) |
| din | input | W | Parallel data for the load operation |
| ser_hi_in | input | 1 | Bit that enters the MSB during a shift toward bit 0 |
| ser_lo_in | input | 1 | Bit that enters bit 0 during a shift toward the MSB |
| dout | output | W | Register content |
| ser_lo_out | output | 1 | Bit 0 of the register, the next bit to leave on a shift toward bit 0 |
| ser_hi_out | output | 1 | MSB of the register, the next bit to leave on a shift toward the MSB |

## Verification
Every operation, including clear, shows its result on `dout` exactly one rising edge after the inputs were presented. The serial outputs follow `dout` in the same cycle, with no extra delay. The bench therefore drives its inputs on the falling edge and lets one rising edge pass. It then compares `dout` and both serial outputs against a behavioural integer model on the next falling edge, so the model is advanced once for each edge. Directed sequences cover a clear issued during active operations, the unused codes, zero-fill and one-fill shifts, and full rotations that must return the starting word. Pseudo-random sequences then cover mixed operations.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'b000,
        OP_LOAD   = 3'b001,
        OP_SHR    = 3'b010,
        OP_SHL    = 3'b011,
        OP_ROR    = 3'b100,
        OP_ROL    = 3'b101
    } op_e;

    // One-hot-or-none control word; none set means hold.
    typedef struct packed {
        logic ld;
        logic shr;
        logic shl;
        logic ror;
        logic rol;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ld: 1'b0, shr: 1'b0, shl: 1'b0, ror: 1'b0, rol: 1'b0};

    function automatic ctl_t decode_op(input logic [2:0] code);
        ctl_t c;
        c = CTL_IDLE;
        case (code)
            OP_LOAD: c.ld  = 1'b1;
            OP_SHR:  c.shr = 1'b1;
            OP_SHL:  c.shl = 1'b1;
            OP_ROR:  c.ror = 1'b1;
            OP_ROL:  c.rol = 1'b1;
            default: c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/usr_decode.sv
module usr_decode
    import usr_pkg::*;
(
    input  logic [2:0] op_sel,
    output ctl_t       ctl
);

    always_comb begin
        ctl = decode_op(op_sel);
    end

    // R2: at most one data path selected, unused codes select none
    always_comb begin
        a_r2_onehot_ctl: assert ($onehot0(ctl))
            else $error("decoder selected more than one path");
    end

endmodule

// File: rtl/usr_cell.sv
module usr_cell
    import usr_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  ctl_t ctl,
    input  logic par_bit,
    input  logic shr_src,
    input  logic shl_src,
    input  logic ror_src,
    input  logic rol_src,
    output logic q
);

    logic nxt;

    always_comb begin
        unique case (1'b1)
            ctl.ld:  nxt = par_bit;
            ctl.shr: nxt = shr_src;
            ctl.shl: nxt = shl_src;
            ctl.ror: nxt = ror_src;
            ctl.rol: nxt = rol_src;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) q <= 1'b0;
        else     q <= nxt;
    end

endmodule

// File: rtl/universal_shreg.sv
module universal_shreg
    import usr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] din,
    input  logic         ser_hi_in,
    input  logic         ser_lo_in,
    output logic [W-1:0] dout,
    output logic         ser_lo_out,
    output logic         ser_hi_out
);

    localparam int MSB = W - 1;

    ctl_t ctl;

    usr_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up_nb;   // neighbour above (toward MSB)
        logic dn_nb;   // neighbour below (toward bit 0)
        logic shr_s, shl_s, ror_s, rol_s;

        if (i == MSB) begin : g_top
            assign up_nb = ser_hi_in;
            assign ror_s = dout[0];
        end else begin : g_mid_hi
            assign up_nb = dout[i+1];
            assign ror_s = dout[i+1];
        end

        if (i == 0) begin : g_bot
            assign dn_nb = ser_lo_in;
            assign rol_s = dout[MSB];
        end else begin : g_mid_lo
            assign dn_nb = dout[i-1];
            assign rol_s = dout[i-1];
        end

        assign shr_s = up_nb;
        assign shl_s = dn_nb;

        usr_cell u_cell (
            .clk     (clk),
            .clr     (clr),
            .ctl     (ctl),
            .par_bit (din[i]),
            .shr_src (shr_s),
            .shl_src (shl_s),
            .ror_src (ror_s),
            .rol_src (rol_s),
            .q       (dout[i])
        );
    end

    assign ser_lo_out = dout[0];
    assign ser_hi_out = dout[MSB];

    a_r1_clear_zero: assert property (@(posedge clk)
        clr |=> (dout == '0));

    a_r2_hold_keeps: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b000 || op_sel == 3'b110 || op_sel == 3'b111) |=> $stable(dout));

    a_r3_load_value: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b001) |=> (dout == $past(din)));

    a_r4_shr_body: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b010) |=> (dout == {$past(ser_hi_in), $past(dout[MSB:1])}));

    a_r5_shl_body: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b011) |=> (dout == {$past(dout[MSB-1:0]), $past(ser_lo_in)}));

    a_r6_ror_wrap: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b100) |=> (dout[MSB] == $past(ser_lo_out)));

    a_r7_rol_wrap: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b101) |=> (dout[0] == $past(ser_hi_out)));

    a_r6_ror_weight: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 3'b100) |=> ($countones(dout) == $countones($past(dout))));

endmodule

// File: tb/sim_universal_shreg.sv
module sim_universal_shreg;

    localparam int W = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr;
    logic [2:0]   op_sel;
    logic [W-1:0] din;
    logic         ser_hi_in;
    logic         ser_lo_in;
    logic [W-1:0] dout;
    logic         ser_lo_out;
    logic         ser_hi_out;

    int n_run  = 0;
    int n_fail = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    universal_shreg #(.W(W)) u0 (
        .clk(clk), .clr(clr), .op_sel(op_sel), .din(din),
        .ser_hi_in(ser_hi_in), .ser_lo_in(ser_lo_in),
        .dout(dout), .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
    );

    function automatic int ref_next(int cur, bit c, int op, int d, bit hi, bit lo);
        int r;
        if (c) return 0;
        case (op)
            1: r = d;
            2: r = (cur >> 1) | (int'(hi) << (W - 1));
            3: r = (cur << 1) | int'(lo);
            4: r = (cur >> 1) | ((cur & 1) << (W - 1));
            5: r = (cur << 1) | ((cur >> (W - 1)) & 1);
            default: r = cur;
        endcase
        return r & MASK;
    endfunction

    task automatic check(string req);
        n_run++;
        if (int'(dout) != model) begin
            n_fail++;
            $display("FAIL %s dout actual=%0h expected=%0h", req, dout, model);
        end
        n_run++;
        if (ser_lo_out != model[0] || ser_hi_out != model[W-1]) begin
            n_fail++;
            $display("FAIL R8 serial outs actual=%b%b expected=%b%b",
                     ser_hi_out, ser_lo_out, model[W-1], model[0]);
        end
    endtask

    // Inputs applied at a falling edge, result compared at the next falling edge.
    task automatic step(bit c, int op, int d, bit hi, bit lo, string req);
        clr = c; op_sel = op[2:0]; din = d[W-1:0]; ser_hi_in = hi; ser_lo_in = lo;
        @(posedge clk);
        model = ref_next(model, c, op, d, hi, lo);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        clr = 1'b1; op_sel = 3'b011; din = '1; ser_hi_in = 1'b1; ser_lo_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model = 0;
        check("R1 reset");

        step(0, 1, 'hA, 1, 1, "R3 load A");
        step(0, 0, 'h5, 1, 1, "R2 hold");
        step(0, 6, 'h3, 0, 0, "R2 code 110");
        step(0, 7, 'hC, 1, 1, "R2 code 111");
        step(0, 2, 0, 0, 0, "R4 shr zero fill");
        step(0, 2, 0, 1, 0, "R4 shr one fill");
        step(0, 3, 0, 0, 0, "R5 shl zero fill");
        step(0, 3, 0, 0, 1, "R5 shl one fill");
        step(0, 1, 'h9, 0, 0, "R3 load 9");
        for (int k = 0; k < W; k++) step(0, 4, 0, 0, 0, "R6 ror");
        n_run++;
        if (int'(dout) != 'h9) begin
            n_fail++;
            $display("FAIL R6 full rotation actual=%0h expected=9", dout);
        end
        for (int k = 0; k < W; k++) step(0, 5, 0, 1, 1, "R7 rol");
        step(0, 1, 'h1, 0, 0, "R3 load 1");
        step(0, 5, 0, 0, 0, "R7 rol");
        step(0, 4, 0, 1, 0, "R6 ror ignores serial");
        step(0, 4, 0, 1, 0, "R6 ror wraps bit0");
        step(0, 1, 'hF, 0, 0, "R3 load F");
        step(1, 1, 'h7, 1, 1, "R1 clear over load");
        step(0, 1, 'h6, 0, 0, "R3 load 6");
        step(1, 5, 0, 1, 1, "R1 clear over rol");
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 7);
            step(($urandom_range(0, 19) == 0), op, $urandom_range(0, MASK),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2-R7 mixed");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule